// File: doc/BRIEF.md
# Fractional-Rate Serial Clock Generator

This block makes the serial clock of an SPI master from a fast reference clock. It does not use an integer divider. A phase accumulator adds a 16-bit rate word on every reference cycle. The accumulator spans 2048 counts, so the serial clock runs at about the reference rate times the word divided by 2048. When the word is 2048/N for a whole N that divides 2048, every serial period is exactly N reference cycles. An optional mode discards the remainder at each wrap, so that every period has the same length when the word does not divide 2048 evenly. A double-rate mode halves the accumulator span, which doubles the serial rate for the same word.

The transfer engine drives a run signal. While run is low, or while the rate word is zero, the clock rests at the level that the polarity input selects and the accumulator is held at zero. Each serial clock edge comes with a one-cycle strobe to the shift logic. A phase input decides which edge launches data and which edge captures it.

Top module: `hsclk_gen`

## Requirements
- R1: While `run` is low, one cycle later `sclk` equals `cpol`, both strobes are low and the accumulator is zero. After `run` rises with word 256 in normal mode, the first strobe appears on the 4th clock edge.
- R2: In normal mode, each running cycle adds the word to the accumulator. The leading edge happens when the sum first reaches 1024. The trailing edge happens when the sum reaches 2048, and 2048 is then subtracted. Word 256 gives a period of 8 cycles, word 128 gives 16 and word 1024 gives 2.
- R3: With `dbl_rate` high, the span is 1024 and the leading-edge threshold is 512. Word 256 then gives a period of 4 cycles.
- R4: With `wrap_clear` high, the accumulator becomes 0 at each trailing edge. Word 300 then yields 292 trailing edges in 2048 cycles. With `wrap_clear` low, the remainder is kept and the same run yields 300.
- R5: `sclk` equals `cpol` XOR the active phase. The active phase is 1 between a leading edge and the next trailing edge.
- R6: With `cpha`=0, `latch_stb` marks leading edges and `launch_stb` marks trailing edges. With `cpha`=1 the two are swapped. The two strobes are never high together.
- R7: Each strobe is one reference cycle wide and is high in exactly the cycle in which `sclk` takes its new level. A strobe is never high in two cycles in a row.
- R8: A word of zero acts like `run` low: no strobes, and `sclk` stays at `cpol`.
- R9: A word above the threshold (1024 in normal mode, 512 in double-rate mode) acts like the threshold itself. The fastest clock is therefore half the reference rate.
- R10: Just after reset, `sclk` equals `cpol` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High while the transfer engine is shifting |
| freq_word | input | 16 | Rate word added per cycle (0 = stopped) |
| wrap_clear | input | 1 | Discard accumulator remainder on each wrap |
| dbl_rate | input | 1 | Halve accumulator span (double-rate clock) |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: capture on leading edge; 1: launch on leading edge |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle strobe on the launch edge |
| latch_stb | output | 1 | One-cycle strobe on the capture edge |

## Verification
The edge assertions assume that `dbl_rate` is changed only while the generator is stopped. Switching span in mid-period could produce a trailing event without a prior leading edge. The assertions also assume that `cpol` is steady while running. The bench follows both rules: it sets every mode, word and polarity during an idle gap with `run` low, and it changes `run` only at falling clock edges. A behavioural model in the bench is compared with the three outputs on every cycle. Directed runs then measure periods, first-edge delay, edge counts over 2048 cycles, and the behaviour when the word is zero.

// File: rtl/hsclk_pkg.sv
package hsclk_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LEAD  = 2'd1,
    EV_TRAIL = 2'd2
  } clk_ev_e;
endpackage

// File: rtl/hsclk_accum.sv
module hsclk_accum
  import hsclk_pkg::*;
#(
  parameter int ACC_W  = 11,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              dbl_rate,
  input  logic              wrap_clear,
  input  logic [WORD_W-1:0] freq_word,
  output clk_ev_e           edge_ev
);
  localparam int SW = ACC_W + 2;
  localparam logic [SW-1:0] SPAN_N = SW'(1 << ACC_W);
  localparam logic [SW-1:0] SPAN_D = SW'(1 << (ACC_W - 1));
  localparam logic [SW-1:0] HALF_N = SW'(1 << (ACC_W - 1));
  localparam logic [SW-1:0] HALF_D = SW'(1 << (ACC_W - 2));

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [SW-1:0]     span_sel, half_sel, w_eff, sum;
  logic [WORD_W-1:0] half_w;
  clk_ev_e           ev_d;

  always_comb begin
    span_sel = dbl_rate ? SPAN_D : SPAN_N;
    half_sel = dbl_rate ? HALF_D : HALF_N;
    half_w   = WORD_W'(half_sel);
    // R9: rate word saturates at the half-span threshold
    w_eff    = (freq_word > half_w) ? half_sel : SW'(freq_word);
    sum      = {2'b00, acc_q} + w_eff;
  end

  always_comb begin
    acc_d = acc_q;
    ev_d  = EV_NONE;
    if (!active) begin
      acc_d = '0;
    end else if (sum >= span_sel) begin
      ev_d  = EV_TRAIL;
      acc_d = wrap_clear ? '0 : ACC_W'(sum - span_sel);
    end else begin
      if (({2'b00, acc_q} < half_sel) && (sum >= half_sel)) ev_d = EV_LEAD;
      acc_d = ACC_W'(sum);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign edge_ev = ev_d;

  assert_acc_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (acc_q == '0));

  assert_no_edge_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (edge_ev == EV_NONE));
endmodule

// File: rtl/hsclk_edge.sv
module hsclk_edge
  import hsclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    active,
  input  logic    cpha,
  input  clk_ev_e edge_ev,
  output logic    phase_q,
  output logic    launch_q,
  output logic    latch_q
);
  logic phase_d, launch_d, latch_d, lead, trail;

  always_comb begin
    lead     = active && (edge_ev == EV_LEAD);
    trail    = active && (edge_ev == EV_TRAIL);
    phase_d  = phase_q;
    if (!active)   phase_d = 1'b0;
    else if (lead) phase_d = 1'b1;
    else if (trail) phase_d = 1'b0;
    launch_d = cpha ? lead : trail;
    latch_d  = cpha ? trail : lead;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      launch_q <= 1'b0;
      latch_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      launch_q <= launch_d;
      latch_q  <= latch_d;
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch_q, latch_q}));

  assert_strobe_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_q || latch_q) |-> (phase_q != $past(phase_q)));

  assert_launch_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |=> !launch_q);

  assert_latch_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |=> !latch_q);
endmodule

// File: rtl/hsclk_gen.sv
module hsclk_gen
  import hsclk_pkg::*;
#(
  parameter int ACC_W  = 11,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WORD_W-1:0] freq_word,
  input  logic              wrap_clear,
  input  logic              dbl_rate,
  input  logic              cpol,
  input  logic              cpha,
  output logic              sclk,
  output logic              launch_stb,
  output logic              latch_stb
);
  logic    active, phase_q;
  clk_ev_e edge_ev;

  assign active = run && (freq_word != '0);

  hsclk_accum #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .dbl_rate   (dbl_rate),
    .wrap_clear (wrap_clear),
    .freq_word  (freq_word),
    .edge_ev    (edge_ev)
  );

  hsclk_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .cpha     (cpha),
    .edge_ev  (edge_ev),
    .phase_q  (phase_q),
    .launch_q (launch_stb),
    .latch_q  (latch_stb)
  );

  // R5: polarity applied after the phase register
  assign sclk = cpol ^ phase_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!launch_stb && !latch_stb && (sclk == cpol)));

  assert_zero_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_word == '0) |=> (!launch_stb && !latch_stb));
endmodule

// File: tb/hsclk_gen_bench.sv
`timescale 1ns/1ps
module hsclk_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, wrap_clear, dbl_rate, cpol, cpha;
  logic [15:0] freq_word;
  logic        sclk, launch_stb, latch_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  hsclk_gen u_hsclk_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .freq_word(freq_word),
    .wrap_clear(wrap_clear), .dbl_rate(dbl_rate), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .launch_stb(launch_stb), .latch_stb(latch_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_acc, m_ph, m_l, m_t;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_ph = 0; m_l = 0; m_t = 0;
    end else begin
      int half, span, we, s, ld, tr;
      bit act;
      act  = run && (freq_word != 0);
      half = dbl_rate ? 512 : 1024;
      span = 2 * half;
      we   = (int'(freq_word) > half) ? half : int'(freq_word);
      s    = m_acc + we;
      ld = 0; tr = 0;
      if (!act) begin
        m_acc = 0; m_ph = 0;
      end else if (s >= span) begin
        tr = 1; m_ph = 0; m_acc = wrap_clear ? 0 : s - span;
      end else begin
        if (m_acc < half && s >= half) begin ld = 1; m_ph = 1; end
        m_acc = s;
      end
      m_l = cpha ? ld : tr;
      m_t = cpha ? tr : ld;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sclk == (cpol ^ m_ph[0]), "R5 sclk vs model", sclk, cpol ^ m_ph[0]);
      chk(launch_stb == m_l[0], "R6 launch vs model", launch_stb, m_l);
      chk(latch_stb == m_t[0], "R6 latch vs model", latch_stb, m_t);
    end
  end

  task automatic setup(input int w, input bit d, input bit c, input bit p, input bit h);
    run = 0;
    @(negedge clk);
    freq_word = 16'(w); dbl_rate = d; wrap_clear = c; cpol = p; cpha = h;
    repeat (3) @(negedge clk);
  endtask

  // Cycles between two successive latch strobes after start
  task automatic period(input int exp, input string tag);
    int n;
    run = 1;
    do @(negedge clk); while (!latch_stb);
    n = 0;
    do begin @(negedge clk); n++; end while (!latch_stb && n < 5000);
    chk(n == exp, tag, n, exp);
  endtask

  task automatic count_launch(input int cycles, input int exp, input string tag);
    int n;
    n = 0;
    run = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (launch_stb) n++;
    end
    chk(n == exp, tag, n, exp);
  endtask

  initial begin
    rst_n = 0; run = 0; freq_word = 0; wrap_clear = 0; dbl_rate = 0;
    cpol = 0; cpha = 0;
    repeat (3) @(negedge clk);
    chk(sclk == 0 && !launch_stb && !latch_stb, "R10 reset state", {sclk, launch_stb, latch_stb}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sclk == cpol && !launch_stb && !latch_stb, "R10 after release", {sclk, launch_stb, latch_stb}, 0);

    // R2 exact division
    setup(256, 0, 0, 0, 0); period(8,  "R2 word 256 period");
    setup(128, 0, 0, 0, 0); period(16, "R2 word 128 period");
    setup(1024, 0, 0, 0, 0); period(2, "R2 word 1024 period");

    // R3 double rate
    setup(256, 1, 0, 0, 0); period(4, "R3 dbl word 256 period");

    // R9 clamp
    setup(5000, 0, 0, 0, 0); period(2, "R9 word 5000 normal");
    setup(5000, 1, 0, 0, 0); period(2, "R9 word 5000 dbl");

    // R4 remainder handling
    setup(300, 0, 1, 0, 0); count_launch(2048, 292, "R4 wrap_clear trail count");
    setup(300, 0, 0, 0, 0); count_launch(2048, 300, "R4 remainder kept trail count");

    // R1 first edge delay and R6 strobe choice
    begin
      int n;
      setup(256, 0, 0, 0, 0);
      run = 1; n = 0;
      do begin @(negedge clk); n++; end while (!launch_stb && !latch_stb && n < 100);
      chk(n == 4, "R1 first edge delay", n, 4);
      chk(latch_stb && !launch_stb, "R6 cpha0 leading is latch", latch_stb, 1);
      run = 0;
      @(negedge clk);
      chk(sclk == cpol && !launch_stb && !latch_stb, "R1 stop returns idle", sclk, cpol);

      setup(256, 0, 0, 1, 1);
      chk(sclk == 1'b1, "R5 cpol1 idle high", sclk, 1);
      run = 1; n = 0;
      do begin @(negedge clk); n++; end while (!launch_stb && !latch_stb && n < 100);
      chk(launch_stb && !latch_stb, "R6 cpha1 leading is launch", launch_stb, 1);
      chk(sclk == 1'b0, "R5 cpol1 active low", sclk, 0);
    end

    // R7 strobe width at fastest rate
    begin
      int bad;
      setup(1024, 0, 0, 0, 1);
      run = 1; bad = 0;
      for (int i = 0; i < 20; i++) begin
        logic pl, pt;
        pl = launch_stb; pt = latch_stb;
        @(negedge clk);
        if ((pl && launch_stb) || (pt && latch_stb)) bad++;
      end
      chk(bad == 0, "R7 strobes single cycle", bad, 0);
    end

    // R8 zero word
    begin
      int cnt;
      setup(0, 0, 0, 1, 0);
      run = 1; cnt = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (launch_stb || latch_stb || sclk != cpol) cnt++;
      end
      chk(cnt == 0, "R8 zero word no activity", cnt, 0);
    end

    run = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule